// File: doc/BRIEF.md
# Read-Ahead Branch Target Buffer

This block predicts branch targets for an instruction-fetch front end. Its entries sit in a synchronous-read memory indexed by fetch-address bits, not in a searched bank of flops. A lookup therefore returns its data one clock after the address is presented. To keep one prediction per fetch, the buffer reads ahead: in every cycle it sends the fetched address plus one instruction step to the memory. In the next cycle it checks the returned entry against the address that is actually being fetched.

The front end drives the address it fetches each cycle and follows the prediction. When the hit output is high, the next fetch is the predicted target. When the front end raises redirect, the next fetch is its own corrected address. Resolved taken branches are installed through the update port. Because the read-ahead address is always sequential, a lookup issued before a taken prediction or a redirect is for the wrong address. Its result is thrown away, which leaves one cycle with no prediction.

A small controller has three states. ST_CLEAR sweeps every index after reset and writes a cleared entry to each. ST_SKIP discards the lookup that is in flight. ST_STREAM passes lookup results through. The transitions are:
- ST_CLEAR to ST_SKIP when the last index has been written.
- ST_SKIP to ST_STREAM unless redirect is high. With redirect high it stays in ST_SKIP.
- ST_STREAM to ST_SKIP on a hit or a redirect. Otherwise it stays in ST_STREAM.

Top module: `sram_btb`

## Requirements
- R1: The result shown in cycle t comes from a read issued in cycle t-1 at address fetch_pc(t-1) + 2^OFS_W. A hit in cycle t requires fetch_pc(t) to equal that address exactly, in all ADDR_W bits.
- R2: The index is fetch address bits [OFS_W+IDX_W-1 : OFS_W] and the tag is bits [OFS_W+IDX_W+TAG_W-1 : OFS_W+IDX_W]. A hit needs a valid entry whose stored tag equals the tag of the looked-up address. Address bits above the tag are not compared, so two addresses that differ only there alias.
- R3: On a hit, pred_tgt_o equals the installed target with its low OFS_W bits forced to zero.
- R4: In the cycle after pred_hit_o is high, pred_hit_o is low. This holds even when the predicted target is the next sequential address and a matching entry exists there.
- R5: In the cycle after redirect_i is high, pred_hit_o is low.
- R6: An update at the same clock edge as a read of the same index does not change that read: it returns the previous entry. The new entry is seen from the following lookup on.
- R7: An update with upd_en_i high writes a valid entry for the index of upd_pc_i, with its tag and with upd_tgt_i as target. It replaces whatever that index held before.
- R8: After reset the block spends 2^IDX_W cycles clearing the valid bit of every index, plus one discarding cycle. pred_hit_o stays low for all of them and updates presented during the sweep are dropped. Entries installed before a reset never hit after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts the clearing sweep |
| fetch_pc_i | input | ADDR_W | Address fetched in this cycle |
| redirect_i | input | 1 | Next fetch is an address not predicted here; flushes the lookup in flight |
| upd_en_i | input | 1 | Install a resolved taken branch |
| upd_pc_i | input | ADDR_W | Address of the branch to install |
| upd_tgt_i | input | ADDR_W | Target of the branch to install |
| pred_hit_o | output | 1 | Prediction valid for fetch_pc_i |
| pred_tgt_o | output | ADDR_W | Predicted target, meaningful when pred_hit_o is high |

## Verification
The bench builds the block with ADDR_W=12, OFS_W=2, IDX_W=3 and TAG_W=4, which gives eight indexes and sixteen tag values. With this size the bench installs a branch at every index and fetches into each of them. It also reaches the aliasing addresses above the tag and tag mismatches at every index. The full reset sweep stays short enough to repeat. A long random phase over the low 256 bytes then mixes updates, redirects, read/write collisions and loops back into installed targets.

// File: rtl/sram_btb_pkg.sv
package sram_btb_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR  = 2'd0,
        ST_SKIP   = 2'd1,
        ST_STREAM = 2'd2
    } btb_state_e;
endpackage

// File: rtl/btb_array.sv
// Single-port-write, registered-read entry store; a read and a write at the
// same edge to the same row return the row's previous contents.
module btb_array #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
        rdata_o <= mem[raddr_i];
    end
endmodule

// File: rtl/btb_ctrl.sv
// Sequencer: clearing sweep after reset, then alternation between passing
// lookup results and discarding the one in flight.
module btb_ctrl
    import sram_btb_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             redirect_i,
    output btb_state_e       state_o,
    output logic             clr_we_o,
    output logic [IDX_W-1:0] clr_idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    btb_state_e       state_q, state_d;
    logic [IDX_W-1:0] clr_q, clr_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            clr_q   <= '0;
        end else begin
            state_q <= state_d;
            clr_q   <= clr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        clr_d   = clr_q;
        unique case (state_q)
            ST_CLEAR: begin
                clr_d = clr_q + 1'b1;
                if (clr_q == LAST_IDX) begin
                    state_d = ST_SKIP;
                end
            end
            ST_SKIP: begin
                state_d = redirect_i ? ST_SKIP : ST_STREAM;
            end
            ST_STREAM: begin
                if (hit_i || redirect_i) begin
                    state_d = ST_SKIP;
                end
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_comb begin
        state_o   = state_q;
        clr_we_o  = (state_q == ST_CLEAR);
        clr_idx_o = clr_q;
    end
endmodule

// File: rtl/btb_match.sv
// Compares the returned entry with the registered look-ahead address and the
// address actually being fetched.
module btb_match #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2,
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 12
) (
    input  logic                    enable_i,
    input  logic                    entry_vld_i,
    input  logic [TAG_W-1:0]        entry_tag_i,
    input  logic [ADDR_W-OFS_W-1:0] entry_tgt_i,
    input  logic [ADDR_W-1:0]       look_addr_i,
    input  logic [ADDR_W-1:0]       fetch_pc_i,
    output logic                    hit_o,
    output logic [ADDR_W-1:0]       tgt_o
);
    localparam int TAG_LSB = OFS_W + IDX_W;

    logic [TAG_W-1:0] look_tag;
    logic             tag_eq;
    logic             addr_eq;

    always_comb begin
        look_tag = look_addr_i[TAG_LSB +: TAG_W];
        tag_eq   = (entry_tag_i == look_tag);
        addr_eq  = (look_addr_i == fetch_pc_i);
        hit_o    = enable_i && entry_vld_i && tag_eq && addr_eq;
        tgt_o    = {entry_tgt_i, {OFS_W{1'b0}}};
    end
endmodule

// File: rtl/sram_btb.sv
module sram_btb
    import sram_btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2,
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc_i,
    input  logic              redirect_i,
    input  logic              upd_en_i,
    input  logic [ADDR_W-1:0] upd_pc_i,
    input  logic [ADDR_W-1:0] upd_tgt_i,
    output logic              pred_hit_o,
    output logic [ADDR_W-1:0] pred_tgt_o
);
    localparam int TGT_W   = ADDR_W - OFS_W;
    localparam int ENT_W   = 1 + TAG_W + TGT_W;
    localparam int TAG_LSB = OFS_W + IDX_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << OFS_W;

    btb_state_e        state;
    logic              clr_we;
    logic [IDX_W-1:0]  clr_idx;
    logic [ADDR_W-1:0] la_addr, la_q;
    logic              w_en;
    logic [IDX_W-1:0]  w_idx;
    logic [ENT_W-1:0]  w_data;
    logic [ENT_W-1:0]  rd_data;
    logic              hit;
    logic              unused_bits;

    // Read ahead: the only guess available is the next sequential address.
    assign la_addr = fetch_pc_i + STEP;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            la_q <= '0;
        end else begin
            la_q <= la_addr;
        end
    end

    // Write port: the sweep owns it while clearing; updates are dropped then.
    always_comb begin
        if (clr_we) begin
            w_en   = 1'b1;
            w_idx  = clr_idx;
            w_data = '0;
        end else begin
            w_en   = upd_en_i;
            w_idx  = upd_pc_i[OFS_W +: IDX_W];
            w_data = {1'b1, upd_pc_i[TAG_LSB +: TAG_W], upd_tgt_i[ADDR_W-1:OFS_W]};
        end
    end

    assign unused_bits = ^{upd_pc_i, upd_tgt_i};

    btb_array #(
        .IDX_W  (IDX_W),
        .DATA_W (ENT_W)
    ) u_array (
        .clk     (clk),
        .we_i    (w_en),
        .waddr_i (w_idx),
        .wdata_i (w_data),
        .raddr_i (la_addr[OFS_W +: IDX_W]),
        .rdata_o (rd_data)
    );

    btb_ctrl #(
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .redirect_i (redirect_i),
        .state_o    (state),
        .clr_we_o   (clr_we),
        .clr_idx_o  (clr_idx)
    );

    btb_match #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W)
    ) u_match (
        .enable_i    (state == ST_STREAM),
        .entry_vld_i (rd_data[ENT_W-1]),
        .entry_tag_i (rd_data[TGT_W +: TAG_W]),
        .entry_tgt_i (rd_data[TGT_W-1:0]),
        .look_addr_i (la_q),
        .fetch_pc_i  (fetch_pc_i),
        .hit_o       (hit),
        .tgt_o       (pred_tgt_o)
    );

    assign pred_hit_o = hit;
endmodule

// File: rtl/sram_btb_chk.sv
module sram_btb_chk #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc_i,
    input logic              redirect_i,
    input logic              pred_hit_o,
    input logic              clearing
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << OFS_W;

    p_seq_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit_o |-> fetch_pc_i == $past(fetch_pc_i) + STEP);

    p_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit_o |=> !pred_hit_o);

    p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> !pred_hit_o);

    p_quiet_sweep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clearing |-> !pred_hit_o);

    p_sweep_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clearing) |-> !pred_hit_o);
endmodule

bind sram_btb sram_btb_chk #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_pc_i (fetch_pc_i),
    .redirect_i (redirect_i),
    .pred_hit_o (pred_hit_o),
    .clearing   (clr_we)
);

// File: tb/sram_btb_tb.sv
`timescale 1ns/1ps
module sram_btb_tb;
    localparam int AW = 12;
    localparam int OB = 2;
    localparam int IW = 3;
    localparam int TW = 4;
    localparam int DEPTH = 1 << IW;
    localparam logic [AW-1:0] STEP = AW'(1) << OB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic [AW-1:0] upd_pc = '0;
    logic [AW-1:0] upd_tgt = '0;
    logic redirect = 1'b0;
    logic upd_en = 1'b0;
    logic pred_hit;
    logic [AW-1:0] pred_tgt;

    always #2 clk = ~clk;

    sram_btb #(.ADDR_W(AW), .OFS_W(OB), .IDX_W(IW), .TAG_W(TW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_pc_i (fetch_pc),
        .redirect_i (redirect),
        .upd_en_i   (upd_en),
        .upd_pc_i   (upd_pc),
        .upd_tgt_i  (upd_tgt),
        .pred_hit_o (pred_hit),
        .pred_tgt_o (pred_tgt)
    );

    // Requirement-level model state
    bit            m_v   [DEPTH];
    logic [TW-1:0] m_tag [DEPTH];
    logic [AW-1:0] m_tgt [DEPTH];
    int            st;        // 0 sweep, 1 discard, 2 stream
    int            clr_cnt;
    bit            cap_v;
    logic [TW-1:0] cap_tag;
    logic [AW-1:0] cap_tgt;
    bit            cap_coll;
    logic [AW-1:0] la_prev;
    logic [AW-1:0] nxt_pc;
    string         why;
    int            n_chk = 0;
    int            n_bad = 0;
    int            wd = 0;

    function automatic logic [IW-1:0] idxf(input logic [AW-1:0] a);
        return a[OB +: IW];
    endfunction

    function automatic logic [TW-1:0] tagf(input logic [AW-1:0] a);
        return a[OB+IW +: TW];
    endfunction

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s pc=%h actual=%h expected=%h", req, fetch_pc, act, exp);
        end
    endtask

    // One fetch cycle; entered and left at a falling edge.
    task automatic cyc(input bit rd, input logic [AW-1:0] rp, input bit ue,
                       input logic [AW-1:0] up, input logic [AW-1:0] ut,
                       input bit fe, input logic [AW-1:0] fp, input bit coll);
        bit eh;
        string lbl;
        logic [AW-1:0] etgt;
        logic [AW-1:0] la;
        logic [IW-1:0] li;
        logic [IW-1:0] ui;
        fetch_pc = fe ? fp : nxt_pc;
        redirect = rd;
        upd_en   = ue;
        upd_pc   = coll ? fetch_pc + STEP : up;
        upd_tgt  = ut;
        #1;
        eh = (st == 2) && cap_v && (cap_tag == tagf(la_prev)) && (la_prev == fetch_pc);
        etgt = cap_tgt;
        if (st == 0)                 lbl = "R8";
        else if (st == 1)            lbl = why;
        else if (la_prev != fetch_pc) lbl = "R1";
        else if (cap_coll)           lbl = "R6";
        else if (eh)                 lbl = "R3 R7";
        else                         lbl = "R2";
        chk({lbl, " hit"}, AW'(pred_hit), AW'(eh));
        if (eh) chk({lbl, " target"}, pred_tgt, etgt);
        @(posedge clk);
        la = fetch_pc + STEP;
        li = idxf(la);
        cap_v = m_v[li];
        cap_tag = m_tag[li];
        cap_tgt = m_tgt[li];
        cap_coll = 1'b0;
        if (st == 0) begin
            m_v[clr_cnt] = 1'b0;
            if (clr_cnt == DEPTH - 1) begin
                st = 1;
                why = "R8";
            end
            clr_cnt++;
        end else begin
            if (ue) begin
                ui = idxf(upd_pc);
                cap_coll = (ui == li);
                m_v[ui] = 1'b1;
                m_tag[ui] = tagf(upd_pc);
                m_tgt[ui] = (upd_tgt >> OB) << OB;
            end
            if (st == 2) begin
                if (eh) begin st = 1; why = "R4"; end
                else if (rd) begin st = 1; why = "R5"; end
            end else begin
                if (rd) begin st = 1; why = "R5"; end
                else st = 2;
            end
        end
        nxt_pc = eh ? etgt : (rd ? rp : fetch_pc + STEP);
        la_prev = la;
        @(negedge clk);
    endtask

    task automatic step();
        cyc(1'b0, '0, 1'b0, '0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic go(input logic [AW-1:0] rp);
        cyc(1'b1, rp, 1'b0, '0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic inst(input logic [AW-1:0] pc, input logic [AW-1:0] tg);
        cyc(1'b0, '0, 1'b1, pc, tg, 1'b0, '0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        redirect = 1'b0;
        upd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        st = 0;
        clr_cnt = 0;
        la_prev = '0;
        nxt_pc = '0;
        cap_v = 1'b0;
        cap_coll = 1'b0;
    endtask

    function automatic logic [AW-1:0] pcs(input int i);
        return AW'((i << OB) | (((i * 5 + 1) & 15) << (OB + IW)));
    endfunction

    always @(posedge clk) begin
        wd++;
        if (wd > 50000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", wd, 50000);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_v[i] = 1'b0;
            m_tag[i] = '0;
            m_tgt[i] = '0;
        end
        do_reset();
        // R8: update during the sweep is dropped; sweep and discard cycle stay quiet
        inst(12'h010, 12'h300);
        repeat (12) step();
        go(12'h000);
        repeat (8) step();

        // R7 R3 R2: a branch at every index, then fetch into each
        for (int i = 0; i < DEPTH; i++) inst(pcs(i), AW'(12'h400 + i * 12'h020 + 1));
        for (int i = 0; i < DEPTH; i++) begin
            go(pcs(i) - 12'h008);
            repeat (4) step();
        end
        // R2: bits above the tag alias
        for (int i = 0; i < DEPTH; i++) begin
            go((pcs(i) | 12'h600) - 12'h008);
            repeat (4) step();
        end
        // R2: tag mismatch at each index misses
        for (int i = 0; i < DEPTH; i++) begin
            go((pcs(i) ^ 12'h020) - 12'h008);
            repeat (4) step();
        end
        // R4: branch to next sequential address still gets a bubble
        inst(12'h104, 12'h108);
        inst(12'h108, 12'h500);
        go(12'h0FC);
        repeat (5) step();
        // R5: redirect straight onto an installed branch
        go(12'h0F8);
        cyc(1'b1, 12'h104, 1'b0, '0, '0, 1'b0, '0, 1'b0);
        repeat (3) step();
        // R6: write at the index being read ahead
        go(12'h200);
        step();
        cyc(1'b0, '0, 1'b1, '0, 12'h700, 1'b0, '0, 1'b1);
        repeat (3) step();
        go(12'h200);
        repeat (4) step();
        // R7: overwrite replaces the target
        inst(12'h104, 12'h600);
        go(12'h0FC);
        repeat (4) step();
        // R1: non-sequential fetch without redirect cannot hit
        go(12'h0F0);
        step();
        cyc(1'b0, '0, 1'b0, '0, '0, 1'b1, 12'h104, 1'b0);
        repeat (3) step();
        // R8: a second reset forgets all entries
        do_reset();
        repeat (10) step();
        go(12'h0FC);
        repeat (4) step();

        // Random mix over the low 256 bytes
        inst(12'h010, 12'h0A0);
        for (int k = 0; k < 600; k++) begin
            int r;
            r = int'($urandom % 16);
            cyc(r == 0, AW'(($urandom % 64) << OB),
                r < 5, AW'(($urandom % 64) << OB), AW'(($urandom % 64) << OB),
                r == 5, AW'(($urandom % 64) << OB), r == 6);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule